// File: doc/BRIEF.md
# Packed Unsigned Media ALU

This block is a one-stage arithmetic unit for video and signal-processing kernels. It takes two packed operand words, each carrying several unsigned lanes, and an operation code. From these it produces one of four results. The first is a sum of absolute lane differences, which scores candidate blocks during a motion search. The second is a per-lane rounded mean, used to blend two predictions when motion is compensated. The third and fourth are a per-lane minimum and a per-lane maximum, used in path-metric selection for trellis decoding.

A request is presented with `req_valid` high, and it is accepted on that rising clock edge. On the next cycle the result appears on a register together with a one-cycle `res_valid` pulse. A new request may be accepted on every cycle. When no request is presented, the result register keeps its last value.

Top module: `pmedia_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted request, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is 1 in exactly the cycle after each edge where `req_valid` was 1, and 0 after each edge where `req_valid` was 0.
- R3: For opcode 2'b00 (difference sum), `res_data` holds the unsigned sum of |a_i − b_i| over all lanes in its low LANES-width-plus-log2 bits (18 bits by default, where 4 × 0xFFFF = 0x3FFFC), with every higher bit cleared.
- R4: For opcode 2'b01 (rounded mean), lane i, which occupies bits [16i+15:16i], holds (a_i + b_i + 1) >> 1 computed without loss of the carry, so that 0xFFFF with 0xFFFF gives 0xFFFF and 1 with 2 gives 2.
- R5: For opcode 2'b10 (minimum), each lane holds the smaller of a_i and b_i compared as unsigned (0x7FFF is below 0x8000).
- R6: For opcode 2'b11 (maximum), each lane holds the larger of a_i and b_i compared as unsigned.
- R7: In a cycle with `req_valid` low, `req_op`, `op_a` and `op_b` are ignored, and `res_data` keeps its previous value.
- R8: Each lane of a mean, minimum or maximum result depends only on the same lane of the two operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request accepted on this edge |
| req_op | input | 2 | Operation code: 00 sum, 01 mean, 10 min, 11 max |
| op_a | input | 64 | First packed operand, four unsigned 16-bit lanes, lane 0 lowest |
| op_b | input | 64 | Second packed operand, same layout |
| res_valid | output | 1 | One-cycle pulse following an accepted request |
| res_data | output | 64 | Registered result |

## Verification
The bench builds the block with its default parameters: four lanes of 16 bits. With that setting the difference sum reaches its widest value, 0x3FFFC, which occupies all 18 result bits. The all-ones mean also exercises the carry into bit 16. At 16 bits the signed and unsigned orderings differ on hand-picked values around 0x8000, which lets the bench tell the two apart. Keeping the lane count small also leaves the ones-complement and order-swapped difference cases checkable with hand-computed expected values.

// File: rtl/pmedia_pkg.sv
package pmedia_pkg;
  typedef enum logic [1:0] {
    OP_SAD = 2'b00,
    OP_AVG = 2'b01,
    OP_MIN = 2'b10,
    OP_MAX = 2'b11
  } pm_op_e;
endpackage

// File: rtl/pmedia_lane.sv
module pmedia_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] absdiff,
  output logic [EW-1:0] avg,
  output logic [EW-1:0] mn,
  output logic [EW-1:0] mx
);
  function automatic logic [EW-1:0] f_absdiff(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  function automatic logic [EW-1:0] f_ravg(input logic [EW-1:0] x, input logic [EW-1:0] y);
    logic [EW:0] wide;
    wide = {1'b0, x} + {1'b0, y} + (EW+1)'(1);
    return wide[EW:1];
  endfunction

  logic a_lt_b;
  assign a_lt_b  = (a < b);
  assign absdiff = f_absdiff(a, b);
  assign avg     = f_ravg(a, b);
  assign mn      = a_lt_b ? a : b;
  assign mx      = a_lt_b ? b : a;

  always_comb begin
    if (!$isunknown({a, b})) begin
      AST_AVG_BOUNDED: assert (avg >= mn && avg <= mx) else $error("mean outside operand range"); // R4
      AST_MIN_LE_MAX: assert (mn <= mx) else $error("min above max"); // R5
    end
  end
endmodule

// File: rtl/pmedia_sad_sum.sv
module pmedia_sad_sum #(
  parameter int LANES = 4,
  parameter int EW    = 16,
  parameter int SW    = EW + $clog2(LANES)
) (
  input  logic [LANES*EW-1:0] diffs,
  output logic [SW-1:0]       sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) begin
      sum = sum + SW'(diffs[i*EW +: EW]);
    end
  end
endmodule

// File: rtl/pmedia_alu.sv
module pmedia_alu #(
  parameter int LANES  = 4,
  parameter int ELEM_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic        res_valid,
  output logic [63:0] res_data
);
  import pmedia_pkg::*;

  localparam int DATA_W = LANES * ELEM_W;
  localparam int SAD_W  = ELEM_W + $clog2(LANES);

  logic [DATA_W-1:0] lane_diff, lane_avg, lane_min, lane_max;
  logic [SAD_W-1:0]  sad_sum;
  logic [DATA_W-1:0] next_res;
  logic              accept;

  assign accept = req_valid;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pmedia_lane #(.EW(ELEM_W)) u_lane (
      .a      (op_a[g*ELEM_W +: ELEM_W]),
      .b      (op_b[g*ELEM_W +: ELEM_W]),
      .absdiff(lane_diff[g*ELEM_W +: ELEM_W]),
      .avg    (lane_avg[g*ELEM_W +: ELEM_W]),
      .mn     (lane_min[g*ELEM_W +: ELEM_W]),
      .mx     (lane_max[g*ELEM_W +: ELEM_W])
    );
  end

  pmedia_sad_sum #(.LANES(LANES), .EW(ELEM_W), .SW(SAD_W)) u_sad (
    .diffs(lane_diff),
    .sum  (sad_sum)
  );

  always_comb begin
    unique case (pm_op_e'(req_op))
      OP_SAD:  next_res = DATA_W'(sad_sum);
      OP_AVG:  next_res = lane_avg;
      OP_MIN:  next_res = lane_min;
      OP_MAX:  next_res = lane_max;
      default: next_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= accept;
      if (accept) res_data <= next_res;
    end
  end

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid) else $error("missing valid pulse"); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid) else $error("valid without request"); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_data)) else $error("result changed while idle"); // R7
  AST_SAD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_SAD) |=> res_data[DATA_W-1:SAD_W] == '0) else $error("sum upper bits set"); // R3
endmodule

// File: tb/pmedia_alu_bench.sv
module pmedia_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_valid;
  logic [63:0] res_data;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pmedia_alu u_pmedia_alu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_data(res_data)
  );

  localparam int NV = 8;
  // {op, a, b, expected}
  localparam logic [193:0] VEC [NV] = '{
    {2'b00, 64'h0001_0002_0003_0004, 64'h0004_0003_0002_0001, 64'h0000_0000_0000_0008},
    {2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_0003_FFFC},
    {2'b00, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0003_FFFC},
    {2'b00, 64'h1234_0000_8000_0010, 64'h1200_0005_7FFF_0100, 64'h0000_0000_0000_012A},
    {2'b01, 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFE_0000_0002, 64'hFFFF_FFFF_0000_0002},
    {2'b01, 64'h0003_0010_8000_0000, 64'h0004_0011_8001_0001, 64'h0004_0011_8001_0001},
    {2'b10, 64'h8000_0001_1234_FFFF, 64'h7FFF_0002_1234_0000, 64'h7FFF_0001_1234_0000},
    {2'b11, 64'h8000_0001_1234_FFFF, 64'h7FFF_0002_1234_0000, 64'h8000_0002_1234_FFFF}
  };
  localparam string TAG [NV] = '{"R3", "R3", "R3", "R3", "R4 R8", "R4 R8", "R5 R8", "R6 R8"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R1", {63'd0, res_valid}, 64'd0);
    check("R1", res_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'd0, res_valid}, 64'd0);
    check("R1", res_data, 64'd0);

    // streamed vectors, one per cycle
    req_valid = 1'b1;
    {req_op, op_a, op_b} = VEC[0][193:64];
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check("R2", {63'd0, res_valid}, 64'd1);
      check(TAG[i], res_data, VEC[i][63:0]);
      if (i + 1 < NV) {req_op, op_a, op_b} = VEC[i+1][193:64];
    end

    // idle cycle with changed inputs: R7, R2
    held = res_data;
    req_valid = 1'b0;
    req_op = 2'b11;
    op_a = 64'hAAAA_AAAA_AAAA_AAAA;
    op_b = 64'h5555_5555_5555_5555;
    @(negedge clk);
    check("R2", {63'd0, res_valid}, 64'd0);
    check("R7", res_data, held);
    @(negedge clk);
    check("R7", res_data, held);

    // lane isolation for R8: change only lane 2 of a
    req_valid = 1'b1;
    req_op = 2'b11;
    op_a = 64'h0010_0020_0030_0040;
    op_b = 64'h0011_0021_0031_0041;
    @(negedge clk);
    check("R6", res_data, 64'h0011_0021_0031_0041);
    op_a = 64'h0010_FFFF_0030_0040;
    @(negedge clk);
    check("R8", res_data, 64'h0011_FFFF_0031_0041);

    // reset mid-run: R1
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {63'd0, res_valid}, 64'd0);
    check("R1", res_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule